// File: doc/BRIEF.md
# Audio ADC Serial Output Port

This block sends a stream of 24-bit two's complement stereo samples over a three-wire serial audio link: a data line, a bit clock and a word clock. Each sample pair comes in on parallel buses with a one-cycle valid strobe. The pair is sent MSB first, left word then right word. The block runs from one system clock, `clk`, whose rate is twice the converter master clock. One MCLK period is therefore two `clk` cycles.

As clock master, the port builds the bit clock and the word clock itself. The master clock can first be halved. The result is then divided by a ratio chosen by a two-bit speed code, so that every frame holds 64 bit clocks. As clock slave, the port takes both clocks from outside. It passes them through a synchronizer, follows their falling edges and measures the slot length, so frames of 32, 64 and 128 bit clocks are served. Both left-justified and I2S framing are supported, and the framing can be changed while the port is running.

Top module: `audio_serial_port`

## Requirements
- R1: While reset is held, and right after it, `sdout`, `sclkOut` and `lrckOut` are low.
- R2: In master mode, the bit clock period is 8, 4 or 2 `clk` cycles for speed code 00, 01 or 10 (single, double, quad). Each period doubles when `halveMclk` is 1.
- R3: In master mode, a frame is 64 bit clocks: 32 with the word clock at one level, then 32 at the other. The word clock and `sdout` change only together with a falling edge of the bit clock.
- R4: Left-justified format (`i2sFmt` = 0): word clock high marks the left slot. Bit 23 is sent in the first bit clock of the slot, then bits 22 down to 0 in turn. The rest of the slot is zero.
- R5: I2S format (`i2sFmt` = 1): word clock low marks the left slot, and every data bit comes one bit clock later than in R4. A format change made at run time applies from the next full frame.
- R6: A pair presented with `sampleValid` is held until the next start of a left slot, and only then copied into the word being sent. Both slots of one frame always carry the same pair, even if a new pair arrives in the middle of the frame.
- R7: In slave mode (`isMaster` = 0), `sdout` takes its new bit within four `clk` cycles of a falling edge on `sclkIn`. A slot starts at the first falling edge after `lrckIn` has changed, and the data placement follows R4 or R5.
- R8: In slave mode with 64 or 128 bit clocks per frame, each slot carries the 24 data bits and then zeros.
- R9: In slave mode with 32 bit clocks per frame, each slot carries only the top 16 bits, 23 down to 8. In I2S format, bit 8 falls in the first bit clock of the following slot.
- R10: Speed code 11 is reserved. While it is applied, `sclkOut`, `lrckOut` and `sdout` are held low.
- R11: In slave mode, `sclkOut` and `lrckOut` stay low and `halveMclk` has no effect on the output stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock at twice the master clock rate |
| rstN | input | 1 | Active-low synchronous reset |
| speedMode | input | 2 | Speed code: 00 single, 01 double, 10 quad, 11 reserved |
| isMaster | input | 1 | 1 = port generates the clocks, 0 = follows external clocks |
| halveMclk | input | 1 | Master mode: halve MCLK before division |
| i2sFmt | input | 1 | 0 = left-justified, 1 = I2S framing |
| sclkIn | input | 1 | External bit clock (slave mode) |
| lrckIn | input | 1 | External word clock (slave mode) |
| sampleLeft | input | 24 | Left sample, two's complement |
| sampleRight | input | 24 | Right sample, two's complement |
| sampleValid | input | 1 | Strobe that captures the sample pair |
| sdout | output | 1 | Serial data out |
| sclkOut | output | 1 | Generated bit clock (master mode) |
| lrckOut | output | 1 | Generated word clock (master mode) |

## Verification
In master mode, all three outputs are registered on the same `clk` edge. The bench therefore acts as a receiver: it samples `sdout` and `lrckOut` at each observed rising edge of `sclkOut`, half a bit period after the data changed. It then compares whole frames, taken from the second full frame after any change of configuration. In slave mode, a falling edge on `sclkIn` reaches `sdout` after three `clk` edges: two synchronizer stages and the output register. The bench drives each bit clock level for four cycles and samples `sdout` at the end of the low phase. The reserved code takes one edge to clear the outputs, so the bench checks them only from the fourth cycle on.

// File: rtl/asp_pkg.sv
package asp_pkg;

  localparam int POS_W = 7;

  typedef enum logic [1:0] {
    SPEED_SINGLE = 2'b00,
    SPEED_DOUBLE = 2'b01,
    SPEED_QUAD   = 2'b10,
    SPEED_RSVD   = 2'b11
  } speed_e;

  // Per-bit strobe bundle from timing control to the data path.
  typedef struct packed {
    logic             bitStart;   // next clk edge starts a new serial bit
    logic             slotStart;  // that bit is the first of a slot
    logic             isLeft;     // that bit lies in the left slot
    logic             narrow;     // slot is only 16 bit clocks long
    logic             quiet;      // reserved speed code, force data low
    logic [POS_W-1:0] pos;        // bit position within the slot
  } strobe_t;

endpackage

// File: rtl/asp_timing.sv
module asp_timing
  import asp_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int SLOT_SCLKS  = 32,
  parameter int NARROW_SLOT = 16,
  parameter int MAX_SHIFT   = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] speedMode,
  input  logic       isMaster,
  input  logic       halveMclk,
  input  logic       i2sFmt,
  input  logic       sclkIn,
  input  logic       lrckIn,
  output logic       sclkOut,
  output logic       lrckOut,
  output strobe_t    stb
);

  localparam int FRAME_SCLKS = 2 * SLOT_SCLKS;
  localparam int BIT_W       = $clog2(FRAME_SCLKS);
  localparam int PRE_W       = MAX_SHIFT;

  logic rsvd;
  assign rsvd = (speed_e'(speedMode) == SPEED_RSVD);

  // ---------------- master clock divider ----------------
  logic [2:0]       shiftK;
  logic [PRE_W-1:0] preLast, preHalf, preCnt, preInc;
  logic [BIT_W-1:0] bitCnt, nextBit;
  logic             mWrap;

  always_comb begin
    case (speed_e'(speedMode))
      SPEED_SINGLE: shiftK = 3'd3 + {2'b00, halveMclk};
      SPEED_DOUBLE: shiftK = 3'd2 + {2'b00, halveMclk};
      default:      shiftK = 3'd1 + {2'b00, halveMclk};
    endcase
  end

  assign preLast = PRE_W'((5'd1 << shiftK) - 5'd1);
  assign preHalf = PRE_W'(5'd1 << (shiftK - 3'd1));
  assign preInc  = PRE_W'(preCnt + 1'b1);
  assign nextBit = BIT_W'(bitCnt + 1'b1);
  assign mWrap   = isMaster && !rsvd && (preCnt >= preLast);

  always_ff @(posedge clk) begin
    if (!rstN || !isMaster || rsvd) begin
      preCnt  <= '0;
      bitCnt  <= '1;
      sclkOut <= 1'b0;
      lrckOut <= 1'b0;
    end else begin
      preCnt  <= mWrap ? '0 : preInc;
      sclkOut <= mWrap ? 1'b0 : (preInc >= preHalf);
      if (mWrap) begin
        bitCnt  <= nextBit;
        lrckOut <= !nextBit[BIT_W-1] ^ i2sFmt;
      end
    end
  end

  // ---------------- slave clock follower ----------------
  logic [SYNC_STAGES-1:0] sclkSync, lrckSync;
  logic                   sclkNow, lrckNow, sclkPrev, lrckLast, lenNarrow;
  logic [POS_W-1:0]       posReg, posNext;
  logic                   sFall, sSlotStart;

  assign sclkNow    = sclkSync[SYNC_STAGES-1];
  assign lrckNow    = lrckSync[SYNC_STAGES-1];
  assign sFall      = !isMaster && !rsvd && sclkPrev && !sclkNow;
  assign sSlotStart = (lrckNow != lrckLast);
  assign posNext    = sSlotStart ? '0 : ((posReg == '1) ? posReg : POS_W'(posReg + 1'b1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclkSync  <= '0;
      lrckSync  <= '0;
      sclkPrev  <= 1'b0;
      lrckLast  <= 1'b0;
      posReg    <= '0;
      lenNarrow <= 1'b0;
    end else begin
      sclkSync <= {sclkSync[SYNC_STAGES-2:0], sclkIn};
      lrckSync <= {lrckSync[SYNC_STAGES-2:0], lrckIn};
      sclkPrev <= sclkNow;
      if (sFall) begin
        lrckLast <= lrckNow;
        posReg   <= posNext;
        if (sSlotStart) lenNarrow <= (posReg < POS_W'(NARROW_SLOT));
      end
    end
  end

  // ---------------- strobe selection ----------------
  always_comb begin
    stb.quiet = rsvd;
    if (isMaster) begin
      stb.bitStart  = mWrap;
      stb.slotStart = (nextBit[BIT_W-2:0] == '0);
      stb.isLeft    = !nextBit[BIT_W-1];
      stb.narrow    = 1'b0;
      stb.pos       = POS_W'(nextBit[BIT_W-2:0]);
    end else begin
      stb.bitStart  = sFall;
      stb.slotStart = sSlotStart;
      stb.isLeft    = lrckNow ^ i2sFmt;
      stb.narrow    = sSlotStart ? (posReg < POS_W'(NARROW_SLOT)) : lenNarrow;
      stb.pos       = posNext;
    end
  end

  // Word clock moves only where the bit clock is left low (falling edge).
  assert_lrck_on_sclk_fall_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(lrckOut) && $past(isMaster && !rsvd)) |-> !sclkOut);

  // Slave mode keeps the generated clocks quiet.
  assert_slave_clocks_low_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!isMaster && $past(!isMaster)) |-> (!sclkOut && !lrckOut));

endmodule

// File: rtl/asp_shifter.sv
module asp_shifter
  import asp_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int NARROW_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             stb,
  input  logic                i2sFmt,
  input  logic [SAMPLE_W-1:0] sampleLeft,
  input  logic [SAMPLE_W-1:0] sampleRight,
  input  logic                sampleValid,
  output logic                sdout
);

  localparam int TAIL_BIT = SAMPLE_W - NARROW_W;

  logic [SAMPLE_W-1:0] pendL, pendR, holdL, holdR, nextL, nextR, word, shifted;
  logic [POS_W-1:0]    idx, lim;
  logic                loadHold, bitVal;

  assign loadHold = stb.bitStart && stb.slotStart && stb.isLeft;
  assign nextL    = loadHold ? pendL : holdL;
  assign nextR    = loadHold ? pendR : holdR;
  assign word     = stb.isLeft ? nextL : nextR;
  assign idx      = i2sFmt ? POS_W'(stb.pos - 1'b1) : stb.pos;
  assign lim      = stb.narrow ? POS_W'(NARROW_W) : POS_W'(SAMPLE_W);
  assign shifted  = word << idx;

  always_comb begin
    if (i2sFmt && (stb.pos == '0)) begin
      // Delayed last bit of the previous slot; only a narrow slot has one left.
      bitVal = stb.narrow && (stb.isLeft ? holdR[TAIL_BIT] : holdL[TAIL_BIT]);
    end else begin
      bitVal = (idx < lim) && shifted[SAMPLE_W-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendL <= '0;
      pendR <= '0;
      holdL <= '0;
      holdR <= '0;
      sdout <= 1'b0;
    end else begin
      if (sampleValid) begin
        pendL <= sampleLeft;
        pendR <= sampleRight;
      end
      holdL <= nextL;
      holdR <= nextR;
      if (stb.quiet)        sdout <= 1'b0;
      else if (stb.bitStart) sdout <= bitVal;
    end
  end

endmodule

// File: rtl/audio_serial_port.sv
module audio_serial_port
  import asp_pkg::*;
#(
  parameter int SAMPLE_W    = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [1:0]          speedMode,
  input  logic                isMaster,
  input  logic                halveMclk,
  input  logic                i2sFmt,
  input  logic                sclkIn,
  input  logic                lrckIn,
  input  logic [SAMPLE_W-1:0] sampleLeft,
  input  logic [SAMPLE_W-1:0] sampleRight,
  input  logic                sampleValid,
  output logic                sdout,
  output logic                sclkOut,
  output logic                lrckOut
);

  strobe_t stb;

  asp_timing #(
    .SYNC_STAGES(SYNC_STAGES),
    .SLOT_SCLKS (32),
    .NARROW_SLOT(16),
    .MAX_SHIFT  (4)
  ) timingCtl (
    .clk      (clk),
    .rstN     (rstN),
    .speedMode(speedMode),
    .isMaster (isMaster),
    .halveMclk(halveMclk),
    .i2sFmt   (i2sFmt),
    .sclkIn   (sclkIn),
    .lrckIn   (lrckIn),
    .sclkOut  (sclkOut),
    .lrckOut  (lrckOut),
    .stb      (stb)
  );

  asp_shifter #(
    .SAMPLE_W(SAMPLE_W),
    .NARROW_W(16)
  ) dataPath (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .i2sFmt     (i2sFmt),
    .sampleLeft (sampleLeft),
    .sampleRight(sampleRight),
    .sampleValid(sampleValid),
    .sdout      (sdout)
  );

  // Master data changes only where the generated bit clock is low.
  assert_sdout_on_sclk_fall_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(sdout) && $past(isMaster && (speedMode != 2'b11))) |-> !sclkOut);

  // Reserved speed code leaves every output low.
  assert_reserved_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    ((speedMode == 2'b11) && $past(speedMode == 2'b11)) |-> (!sdout && !sclkOut && !lrckOut));

endmodule

// File: tb/audio_serial_port_test.sv
module audio_serial_port_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  speedMode = 2'b00;
  logic        isMaster = 1'b1;
  logic        halveMclk = 1'b0;
  logic        i2sFmt = 1'b0;
  logic        sclkIn = 1'b1;
  logic        lrckIn = 1'b0;
  logic [23:0] sampleLeft = '0;
  logic [23:0] sampleRight = '0;
  logic        sampleValid = 1'b0;
  logic        sdout, sclkOut, lrckOut;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  audio_serial_port uut (
    .clk(clk), .rstN(rstN), .speedMode(speedMode), .isMaster(isMaster),
    .halveMclk(halveMclk), .i2sFmt(i2sFmt), .sclkIn(sclkIn), .lrckIn(lrckIn),
    .sampleLeft(sampleLeft), .sampleRight(sampleRight), .sampleValid(sampleValid),
    .sdout(sdout), .sclkOut(sclkOut), .lrckOut(lrckOut)
  );

  task automatic check(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // Master run: receive frames at rising bit clock edges and compare.
  task automatic runMaster(input logic [1:0] spd, input logic hv, input logic fmt,
                           input logic [23:0] aL, input logic [23:0] aR,
                           input logic swap, input logic [23:0] bL, input logic [23:0] bR);
    logic [259:0] bits, lr;
    int starts[3];
    int nStarts = 0;
    int rise = 0;
    int cyc = 0;
    int lastRise = 0;
    int period = 0;
    logic prevS, prevLeft, curLeft;
    @(negedge clk);
    speedMode = spd; halveMclk = hv; i2sFmt = fmt; isMaster = 1'b1;
    sampleLeft = aL; sampleRight = aR; sampleValid = 1'b1;
    @(negedge clk);
    sampleValid = 1'b0;
    prevS = sclkOut;
    prevLeft = 1'b1;
    bits = '0; lr = '0;
    while (rise < 260) begin
      @(negedge clk);
      cyc++;
      if (sampleValid) sampleValid = 1'b0;
      if (sclkOut && !prevS) begin
        bits[rise] = sdout;
        lr[rise] = lrckOut;
        curLeft = lrckOut ^ fmt;
        if (curLeft && !prevLeft && nStarts < 3) begin
          starts[nStarts] = rise;
          nStarts++;
        end
        if (swap && nStarts == 2 && rise == starts[1] + 5) begin
          sampleLeft = bL; sampleRight = bR; sampleValid = 1'b1;
        end
        if (rise > 0) period = cyc - lastRise;
        lastRise = cyc;
        prevLeft = curLeft;
        rise++;
      end
      prevS = sclkOut;
    end
    begin
      int expPeriod = 2 * (hv ? 2 : 1) * ((spd == 2'd0) ? 4 : (spd == 2'd1) ? 2 : 1);
      check(period == expPeriod, "R2 bit clock period", 128'(period), 128'(expPeriod));
    end
    check(nStarts == 3, "R3 left slot starts seen", 128'(nStarts), 128'd3);
    if (nStarts == 3) begin
      for (int f = 1; f < 3; f++) begin
        logic [23:0] wL, wR;
        logic [63:0] gotD, expD;
        logic [64:0] gotL, expL;
        wL = (swap && f == 2) ? bL : aL;
        wR = (swap && f == 2) ? bR : aR;
        for (int j = 0; j < 65; j++) begin
          int pos = j % 32;
          logic left = (j % 64) < 32;
          int pp = pos - (fmt ? 1 : 0);
          logic [23:0] w = left ? wL : wR;
          gotL[j] = lr[starts[f] + j];
          expL[j] = left ^ fmt;
          if (j < 64) begin
            gotD[j] = bits[starts[f] + j];
            expD[j] = (pp >= 0 && pp < 24) ? w[23 - pp] : 1'b0;
          end
        end
        check(gotL == expL, "R3 word clock frame", 128'(gotL), 128'(expL));
        if (swap)
          check(gotD == expD, "R6 pair held per frame", 128'(gotD), 128'(expD));
        else if (fmt)
          check(gotD == expD, "R5 I2S frame data", 128'(gotD), 128'(expD));
        else
          check(gotD == expD, "R4 left-justified frame data", 128'(gotD), 128'(expD));
      end
    end
  endtask

  // Slave run: drive external clocks, sample data at the end of each low phase.
  task automatic runSlave(input int ratio, input logic fmt,
                          input logic [23:0] aL, input logic [23:0] aR);
    logic [383:0] got;
    int slot = ratio / 2;
    int badClk = 0;
    @(negedge clk);
    speedMode = 2'b00; isMaster = 1'b0; halveMclk = 1'b1; i2sFmt = fmt;
    sampleLeft = aL; sampleRight = aR; sampleValid = 1'b1;
    @(negedge clk);
    sampleValid = 1'b0;
    got = '0;
    for (int f = 0; f < 3; f++) begin
      for (int b = 0; b < ratio; b++) begin
        @(negedge clk);
        sclkIn = 1'b0;
        lrckIn = (b < slot) ^ fmt;
        repeat (4) @(negedge clk);
        got[f * ratio + b] = sdout;
        if (sclkOut || lrckOut) badClk++;
        sclkIn = 1'b1;
        repeat (3) @(negedge clk);
      end
    end
    check(badClk == 0, "R11 master clocks low in slave", 128'(badClk), 128'd0);
    begin
      logic [127:0] gotF, expF;
      int lim = (slot < 24) ? slot : 24;
      gotF = '0; expF = '0;
      for (int j = 0; j < ratio; j++) begin
        int pos = j % slot;
        logic left = j < slot;
        int pp = pos - (fmt ? 1 : 0);
        logic [23:0] w = left ? aL : aR;
        gotF[j] = got[2 * ratio + j];
        if (pp < 0) expF[j] = (slot == 16) ? (left ? aR[8] : aL[8]) : 1'b0;
        else        expF[j] = (pp < lim) ? w[23 - pp] : 1'b0;
      end
      if (ratio == 32)
        check(gotF == expF, "R9 R7 slave 16-bit slots", gotF, expF);
      else
        check(gotF == expF, "R8 R7 slave wide slots", gotF, expF);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin : main
    int idx = 0;
    repeat (5) @(negedge clk);
    check(!sdout && !sclkOut && !lrckOut, "R1 outputs in reset",
          128'({sdout, sclkOut, lrckOut}), 128'd0);
    rstN = 1'b1;
    @(negedge clk);
    check(!sdout && !sclkOut && !lrckOut, "R1 outputs after reset",
          128'({sdout, sclkOut, lrckOut}), 128'd0);

    // Master sweep: every speed, divider setting and format.
    for (int s = 0; s < 3; s++) begin
      for (int h = 0; h < 2; h++) begin
        for (int fm = 0; fm < 2; fm++) begin
          logic [23:0] l = 24'h9A3C51 + 24'(idx * 24'h0F1E2D);
          logic [23:0] r = ~l ^ 24'h35F00A;
          runMaster(2'(s), 1'(h), 1'(fm), l, r, 1'b0, '0, '0);
          idx++;
        end
      end
    end

    // R6: new pair arrives inside the left slot.
    runMaster(2'd2, 1'b0, 1'b0, 24'hC0FFEE, 24'h13579B, 1'b1, 24'h7E5A01, 24'hA0B1C2);

    // R10: reserved speed code.
    begin
      int bad = 0;
      @(negedge clk);
      speedMode = 2'b11;
      repeat (3) @(negedge clk);
      for (int k = 0; k < 50; k++) begin
        @(negedge clk);
        if (sdout || sclkOut || lrckOut) bad++;
      end
      check(bad == 0, "R10 reserved code quiet", 128'(bad), 128'd0);
    end

    // Slave sweep: each frame ratio in both formats.
    runSlave(64, 1'b0, 24'h8ACE13, 24'h2468BD);
    runSlave(64, 1'b1, 24'h5A5A3C, 24'hF0E1D2);
    runSlave(128, 1'b0, 24'hB7D911, 24'h40C0FF);
    runSlave(128, 1'b1, 24'h0137FE, 24'hE6543B);
    runSlave(32, 1'b0, 24'hD3A1C4, 24'h6B0F77);
    runSlave(32, 1'b1, 24'hA5C3F1, 24'h1E2D4B);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule